// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block picks one winner among the pending interrupt and reset sources of a small 16-bit microcontroller. It then presents the address of that winner's vector word so that the CPU can load the handler address from it. There are sixteen priority slots. Slot 0 is the reset class and owns the top vector word. Slot 1 is a nonmaskable group, whose lines are gated only by their own enables. The remaining fourteen slots are maskable sources, and each of them needs both its own enable and the global interrupt enable. A lower slot index means a higher priority, and each step down in priority moves the vector address two bytes lower.

The block also watches the CPU fetch address. A fetch from the peripheral register space counts as a reset event. At the first clock after reset is released, the block samples a flag that says whether the reset vector holds the erased value. If it does, the block asks the system to enter the deepest sleep mode and keeps asking until the next reset. The chosen vector is registered and stays frozen while the request is raised, until the CPU acknowledges it.

Top module: `ivc_top`

## Requirements
- R1: Coming out of reset, `irq_req_o`, `rst_req_o` and `sleep_req_o` are 0 and `vec_addr_o` is 0x0000.
- R2: The vector address of slot k is 0xFFFE minus 2·k. The reset class (k=0) uses 0xFFFE, the nonmaskable group (k=1) uses 0xFFFC, and maskable line i (k=i+2) uses 0xFFFA−2·i, down to 0xFFE0 for line 13.
- R3: When several enabled slots are pending at once, the slot with the lowest index wins. Reset beats the nonmaskable group, which beats every maskable line, and maskable line 0 beats line 13.
- R4: Maskable line i is pending only when `irq_flag_i[i]`, `irq_en_i[i]` and `gie_i` are all 1. If any of the three is 0, that line raises no request.
- R5: The nonmaskable group is pending when any bit of `nmi_flag_i & nmi_en_i` is 1. `gie_i` has no effect on it, and a flag whose own enable is 0 raises no request.
- R6: When `irq_req_o` is 0 and a slot is pending at a clock edge, `irq_req_o` becomes 1 after that edge and `vec_addr_o` shows the winner. While `irq_req_o` is 1 and `ack_i` is 0, `vec_addr_o` does not change, even if a higher-priority source arrives. An edge with `ack_i`=1 clears `irq_req_o`, and the next edge arbitrates again.
- R7: A fetch with `fetch_valid_i`=1 at an address from 0x0000 to 0x01FF sets `rst_req_o` after the next edge and makes the reset class pending. A fetch at 0x0200 or above does not, and neither does any address while `fetch_valid_i`=0.
- R8: When any bit of `rst_src_i` is 1 at an edge, `rst_req_o` is 1 after that edge and the reset class is pending (vector 0xFFFE), whatever the state of the enables.
- R9: `sleep_req_o` takes the value of `rst_vec_erased_i` at the first clock edge after the internal reset is released and holds it until the next reset. Later changes of `rst_vec_erased_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rst_src_i | input | NUM_RST | Reset-class event lines |
| nmi_flag_i | input | NUM_NMI | Nonmaskable group event flags |
| nmi_en_i | input | NUM_NMI | Individual enables of the nonmaskable flags |
| irq_flag_i | input | NUM_MASK | Maskable source flags, bit 0 highest priority |
| irq_en_i | input | NUM_MASK | Maskable source enables |
| gie_i | input | 1 | Global enable for maskable sources |
| fetch_valid_i | input | 1 | CPU instruction fetch strobe |
| fetch_addr_i | input | 16 | CPU instruction fetch address |
| rst_vec_erased_i | input | 1 | Reset vector word reads the erased value |
| ack_i | input | 1 | CPU acknowledge of the presented vector |
| irq_req_o | output | 1 | Vector request to the CPU |
| vec_addr_o | output | 16 | Address of the winning vector word |
| rst_req_o | output | 1 | Reset request |
| sleep_req_o | output | 1 | Request to enter the deepest sleep mode |

## Verification
The bench targets these corner cases:
- **Extreme maskable lines.** It drives lines 0 and 13 alone, together with other lines, and with every enable set. A design with reversed priority, or a wrong address step, would show the wrong vector.
- **Masking and the nonmaskable group.** It clears `gie_i` while the nonmaskable group is pending. A design that gated that group with the global enable would stay silent. A design that ignored an individual enable would raise a request with no enabled source.
- **Frozen vector.** It raises a higher-priority source while an earlier vector is still unacknowledged. A design that re-arbitrated at every edge would change the address under the CPU.
- **Fetch boundary.** It probes the fetch boundary at 0x01FF and 0x0200, and fetches address 0x0000 with the strobe low. An off-by-one or unqualified compare would reset the wrong fetches.
- **Erased-vector flag.** It toggles the flag after the boot sample. A design that did not latch the sample would follow the live input.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int ADDR_W = 16;
  localparam logic [ADDR_W-1:0] VEC_TOP       = 16'hFFFE;
  localparam logic [ADDR_W-1:0] ILLEGAL_LIMIT = 16'h0200;

  // slot k -> vector word address, descending in 2-byte steps
  function automatic logic [ADDR_W-1:0] slot_vector(input logic [7:0] idx);
    return VEC_TOP - {7'd0, idx, 1'b0};
  endfunction
endpackage

// File: rtl/ivc_rst_sync.sv
module ivc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_s_n <= stage_q;
    end
  end
endmodule

// File: rtl/ivc_fetch_guard.sv
module ivc_fetch_guard
  import ivc_pkg::*;
(
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              illegal_o
);
  // fetch from peripheral register space is a reset event
  assign illegal_o = fetch_valid_i && (fetch_addr_i < ILLEGAL_LIMIT);
endmodule

// File: rtl/ivc_prio_enc.sv
module ivc_prio_enc #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest index has highest priority
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign valid_o = |req_i;
endmodule

// File: rtl/ivc_boot_sleep.sv
module ivc_boot_sleep (
  input  logic clk,
  input  logic rst_s_n,
  input  logic erased_i,
  output logic sleep_o
);
  logic done_q, done_d, sleep_d, boot_en;

  assign boot_en = !done_q;

  always_comb begin
    done_d  = done_q;
    sleep_d = sleep_o;
    if (boot_en) begin
      done_d  = 1'b1;
      sleep_d = erased_i;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      done_q  <= 1'b0;
      sleep_o <= 1'b0;
    end else begin
      done_q  <= done_d;
      sleep_o <= sleep_d;
    end
  end
endmodule

// File: rtl/ivc_top.sv
module ivc_top
  import ivc_pkg::*;
#(
  parameter int NUM_MASK = 14,
  parameter int NUM_NMI  = 3,
  parameter int NUM_RST  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_RST-1:0]  rst_src_i,
  input  logic [NUM_NMI-1:0]  nmi_flag_i,
  input  logic [NUM_NMI-1:0]  nmi_en_i,
  input  logic [NUM_MASK-1:0] irq_flag_i,
  input  logic [NUM_MASK-1:0] irq_en_i,
  input  logic                gie_i,
  input  logic                fetch_valid_i,
  input  logic [15:0]         fetch_addr_i,
  input  logic                rst_vec_erased_i,
  input  logic                ack_i,
  output logic                irq_req_o,
  output logic [15:0]         vec_addr_o,
  output logic                rst_req_o,
  output logic                sleep_req_o
);
  localparam int NUM_SLOT = NUM_MASK + 2;
  localparam int IDX_W    = $clog2(NUM_SLOT);

  logic                rst_s_n;
  logic                illegal_fetch;
  logic [NUM_SLOT-1:0] pend;
  logic                win_valid;
  logic [IDX_W-1:0]    win_idx;
  logic                req_q, req_d, rst_q, rst_d;
  logic [15:0]         vec_q, vec_d;

  ivc_rst_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  ivc_fetch_guard u_guard (
    .fetch_valid_i (fetch_valid_i),
    .fetch_addr_i  (fetch_addr_i),
    .illegal_o     (illegal_fetch)
  );

  // slot 0: reset class, slot 1: nonmaskable group, slots 2..: maskable
  assign pend[0] = (|rst_src_i) | illegal_fetch;
  assign pend[1] = |(nmi_flag_i & nmi_en_i);

  for (genvar g = 0; g < NUM_MASK; g++) begin : g_mask
    assign pend[g+2] = irq_flag_i[g] & irq_en_i[g] & gie_i;
  end

  ivc_prio_enc #(.N(NUM_SLOT), .IDX_W(IDX_W)) u_enc (
    .req_i   (pend),
    .valid_o (win_valid),
    .idx_o   (win_idx)
  );

  // next state: capture when idle, freeze until acknowledge
  always_comb begin
    req_d = req_q;
    vec_d = vec_q;
    rst_d = pend[0];
    if (req_q) begin
      if (ack_i) req_d = 1'b0;
    end else if (win_valid) begin
      req_d = 1'b1;
      vec_d = slot_vector(8'(win_idx));
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      req_q <= 1'b0;
      vec_q <= '0;
      rst_q <= 1'b0;
    end else begin
      req_q <= req_d;
      vec_q <= vec_d;
      rst_q <= rst_d;
    end
  end

  ivc_boot_sleep u_boot (
    .clk      (clk),
    .rst_s_n  (rst_s_n),
    .erased_i (rst_vec_erased_i),
    .sleep_o  (sleep_req_o)
  );

  assign irq_req_o  = req_q;
  assign vec_addr_o = vec_q;
  assign rst_req_o  = rst_q;
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker #(
  parameter int NUM_MASK = 14,
  parameter int NUM_NMI  = 3,
  parameter int NUM_RST  = 2
) (
  input logic                clk,
  input logic                rst_s_n,
  input logic [NUM_RST-1:0]  rst_src_i,
  input logic [NUM_NMI-1:0]  nmi_flag_i,
  input logic [NUM_NMI-1:0]  nmi_en_i,
  input logic [NUM_MASK-1:0] irq_flag_i,
  input logic                gie_i,
  input logic                fetch_valid_i,
  input logic [15:0]         fetch_addr_i,
  input logic                ack_i,
  input logic                irq_req_o,
  input logic [15:0]         vec_addr_o,
  input logic                rst_req_o,
  input logic                sleep_req_o
);
  logic bad_fetch, rst_any, nmi_any;
  assign bad_fetch = fetch_valid_i && (fetch_addr_i <= 16'h01FF);
  assign rst_any   = (|rst_src_i) || bad_fetch;
  assign nmi_any   = |(nmi_flag_i & nmi_en_i);

  p_vec_range_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_req_o |-> (vec_addr_o >= 16'hFFE0) && !vec_addr_o[0]);

  p_mask_blocked_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!irq_req_o && !gie_i && !rst_any && !nmi_any) |=> !irq_req_o);

  p_nmi_no_gie_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!irq_req_o && nmi_any && !rst_any) |=> (irq_req_o && vec_addr_o == 16'hFFFC));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (irq_req_o && !ack_i) |=> (irq_req_o && $stable(vec_addr_o)));

  p_ack_drop_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (irq_req_o && ack_i) |=> !irq_req_o);

  p_bad_fetch_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    bad_fetch |=> rst_req_o);

  p_rst_src_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (|rst_src_i) |=> rst_req_o);

  p_sleep_hold_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    sleep_req_o |=> sleep_req_o);
endmodule

bind ivc_top ivc_checker #(
  .NUM_MASK (NUM_MASK),
  .NUM_NMI  (NUM_NMI),
  .NUM_RST  (NUM_RST)
) u_ivc_checker (
  .clk           (clk),
  .rst_s_n       (rst_s_n),
  .rst_src_i     (rst_src_i),
  .nmi_flag_i    (nmi_flag_i),
  .nmi_en_i      (nmi_en_i),
  .irq_flag_i    (irq_flag_i),
  .gie_i         (gie_i),
  .fetch_valid_i (fetch_valid_i),
  .fetch_addr_i  (fetch_addr_i),
  .ack_i         (ack_i),
  .irq_req_o     (irq_req_o),
  .vec_addr_o    (vec_addr_o),
  .rst_req_o     (rst_req_o),
  .sleep_req_o   (sleep_req_o)
);

// File: tb/test_ivc_top.sv
module test_ivc_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  rst_src;
  logic [2:0]  nmi_flag, nmi_en;
  logic [13:0] irq_flag, irq_en;
  logic        gie, fetch_valid, erased, ack;
  logic [15:0] fetch_addr;
  logic        irq_req, rst_req, sleep_req;
  logic [15:0] vec;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ivc_top i_ivc_top (
    .clk(clk), .rst_n(rst_n), .rst_src_i(rst_src), .nmi_flag_i(nmi_flag),
    .nmi_en_i(nmi_en), .irq_flag_i(irq_flag), .irq_en_i(irq_en), .gie_i(gie),
    .fetch_valid_i(fetch_valid), .fetch_addr_i(fetch_addr),
    .rst_vec_erased_i(erased), .ack_i(ack), .irq_req_o(irq_req),
    .vec_addr_o(vec), .rst_req_o(rst_req), .sleep_req_o(sleep_req)
  );

  // {gie, irq_en, irq_flag, nmi_en, nmi_flag, rst_src, exp_req, exp_vec}
  localparam int NT = 11;
  localparam logic [53:0] TBL [NT] = '{
    {1'b1, 14'h0001, 14'h0001, 3'h0, 3'h0, 2'h0, 1'b1, 16'hFFFA}, // R2 line 0
    {1'b1, 14'h3FFF, 14'h2000, 3'h0, 3'h0, 2'h0, 1'b1, 16'hFFE0}, // R2 line 13
    {1'b1, 14'h3FFF, 14'h2090, 3'h0, 3'h0, 2'h0, 1'b1, 16'hFFF2}, // R3 line 4 wins
    {1'b0, 14'h3FFF, 14'h3FFF, 3'h0, 3'h0, 2'h0, 1'b0, 16'h0000}, // R4 gie off
    {1'b1, 14'h0000, 14'h3FFF, 3'h0, 3'h0, 2'h0, 1'b0, 16'h0000}, // R4 enables off
    {1'b1, 14'h3FF0, 14'h0018, 3'h0, 3'h0, 2'h0, 1'b1, 16'hFFF2}, // R4 line 3 masked
    {1'b0, 14'h0000, 14'h0000, 3'h1, 3'h1, 2'h0, 1'b1, 16'hFFFC}, // R5 no gie
    {1'b0, 14'h0000, 14'h0000, 3'h0, 3'h7, 2'h0, 1'b0, 16'h0000}, // R5 own enable off
    {1'b1, 14'h3FFF, 14'h3FFF, 3'h4, 3'h4, 2'h0, 1'b1, 16'hFFFC}, // R3 nmi over mask
    {1'b1, 14'h3FFF, 14'h3FFF, 3'h7, 3'h7, 2'h1, 1'b1, 16'hFFFE}, // R8 reset wins
    {1'b0, 14'h0000, 14'h0000, 3'h0, 3'h0, 2'h2, 1'b1, 16'hFFFE}  // R8 no enables
  };

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    rst_src = '0; nmi_flag = '0; nmi_en = '0; irq_flag = '0; irq_en = '0;
    gie = 1'b0; fetch_valid = 1'b0; fetch_addr = 16'h4000; ack = 1'b0;
  endtask

  task automatic do_ack();
    idle_inputs();
    ack = 1'b1;
    tick();
    ack = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    erased = 1'b0;
    do_reset();

    // R1 reset state
    chk("R1 irq_req", 32'(irq_req), 0);
    chk("R1 vec", 32'(vec), 0);
    chk("R1 rst_req", 32'(rst_req), 0);
    chk("R1 sleep_req", 32'(sleep_req), 0);

    // vector table
    for (int i = 0; i < NT; i++) begin
      logic [53:0] e;
      e = TBL[i];
      gie = e[53]; irq_en = e[52:39]; irq_flag = e[38:25];
      nmi_en = e[24:22]; nmi_flag = e[21:19]; rst_src = e[18:17];
      tick();
      chk("R2/R3/R4/R5 req", 32'(irq_req), 32'(e[16]));
      if (e[16]) chk("R2/R3 vec", 32'(vec), 32'(e[15:0]));
      chk("R8 rst_req", 32'(rst_req), 32'(|e[18:17]));
      do_ack();
      chk("R6 req after ack", 32'(irq_req), 0);
      tick();
    end

    // R6 hold against a higher-priority arrival, then re-arbitrate
    gie = 1'b1; irq_en = 14'h3FFF; irq_flag = 14'h0020;
    tick();
    chk("R6 capture", 32'(vec), 32'hFFF0);
    irq_flag = 14'h0021; nmi_en = 3'h2; nmi_flag = 3'h2;
    tick(3);
    chk("R6 held req", 32'(irq_req), 1);
    chk("R6 held vec", 32'(vec), 32'hFFF0);
    ack = 1'b1;
    tick();
    ack = 1'b0;
    chk("R6 ack drop", 32'(irq_req), 0);
    tick();
    chk("R6 rearbitrate", 32'(vec), 32'hFFFC);
    do_ack();
    tick();

    // R7 fetch boundary
    fetch_valid = 1'b1; fetch_addr = 16'h0200;
    tick();
    chk("R7 0x0200 rst_req", 32'(rst_req), 0);
    chk("R7 0x0200 irq_req", 32'(irq_req), 0);
    fetch_valid = 1'b0; fetch_addr = 16'h0000;
    tick();
    chk("R7 no strobe", 32'(rst_req), 0);
    fetch_valid = 1'b1; fetch_addr = 16'h01FF;
    tick();
    chk("R7 0x01FF rst_req", 32'(rst_req), 1);
    chk("R7 0x01FF vec", 32'(vec), 32'hFFFE);
    fetch_addr = 16'h0000;
    tick();
    chk("R7 0x0000 rst_req", 32'(rst_req), 1);
    do_ack();
    tick();
    chk("R7 released", 32'(rst_req), 0);

    // R9 boot sample latched
    erased = 1'b1;
    tick(3);
    chk("R9 late erased ignored", 32'(sleep_req), 0);
    do_reset();
    chk("R9 erased at boot", 32'(sleep_req), 1);
    erased = 1'b0;
    tick(3);
    chk("R9 sleep held", 32'(sleep_req), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule